// File: doc/BRIEF.md
# Dual-Rail Completion Detector

This block watches an N-bit word carried on pairs of wires, one "true" rail and one "false" rail per bit, and reports when every bit of the word has settled. The encoding is redundant. Both rails low means the bit has not yet settled. A single high rail gives the bit's value. Both rails high is a fault. Completion is therefore read from the data itself and does not wait out a fixed worst-case delay.

A `start` input sets the phase. While `start` is low the block treats every pair as unsettled, whatever the wires carry. This is the reset-to-spacer, or precharge, phase. While `start` is high the producing logic raises one rail per bit, and the block reports word completion once every pair shows a high rail. It also presents the decoded single-rail word while completion holds, and it flags any pair that carries the fault code.

All logic runs on a single clock, and every output comes from a register. An output therefore reflects the rails and `start` as sampled at the previous rising edge.

Top module: `dr_done_detect`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after reset, `done`, `err` and `word` are all zero.
- R2: If `start` is low at a clock edge, `done` is 0 after that edge, whatever the rails carry.
- R3: If `start` is high at an edge and every bit has at least one rail high, `done` is 1 after that edge. The per-bit completion is the OR of its two rails, and the word completion is the AND of those ORs.
- R4: If `start` is high at an edge and any bit has both rails low (the spacer code), `done` is 0 after that edge.
- R5: When `done` is 1, bit i of `word` equals the true rail of bit i sampled at the same edge. A lone true rail decodes to 1, and a lone false rail decodes to 0.
- R6: When `done` is 0, `word` is all zeros.
- R7: If `start` is high at an edge and any bit has both rails high, `err` is 1 after that edge. Otherwise `err` is 0.
- R8: While `start` is low, pairs carrying both rails high raise neither `err` nor `done`, because the block forces every pair to the spacer code.
- R9: A pair with both rails high still counts as complete. Its decoded value is 1, taken from the true rail.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | High selects the evaluate phase; low forces all pairs to spacer |
| rail_t | input | N | True rail of each bit |
| rail_f | input | N | False rail of each bit |
| done | output | 1 | Registered word completion |
| err | output | 1 | Registered fault flag for any pair with both rails high |
| word | output | N | Registered decoded word, zero unless `done` is high |

## Verification
The properties assume only that the rails and `start` are stable around the rising edge. They do not assume that the producer obeys the one-rail rule: the fault code is a legal stimulus whose result is defined. The stimulus changes its inputs only at falling edges. It sweeps every value of the 8-bit word with all rails resolved, and it drives each bit in turn into the spacer code and then into the fault code. It also replays tokens in which each bit resolves after a random number of cycles, with a spacer phase between tokens, so that `done` is seen to rise exactly one edge after the last bit settles.

// File: rtl/dr_detect_pkg.sv
package dr_detect_pkg;

    // Pair code, written as {true rail, false rail}
    typedef enum logic [1:0] {
        PAIR_SPACER = 2'b00,
        PAIR_ZERO   = 2'b01,
        PAIR_ONE    = 2'b10,
        PAIR_FAULT  = 2'b11
    } pair_code_t;

endpackage

// File: rtl/dr_rail_gate.sv
module dr_rail_gate #(
    parameter int N = 8
) (
    input  logic         start,
    input  logic [N-1:0] rail_t_i,
    input  logic [N-1:0] rail_f_i,
    output logic [N-1:0] rail_t_o,
    output logic [N-1:0] rail_f_o
);

    // Precharge phase: every pair is seen as spacer
    always_comb begin
        rail_t_o = start ? rail_t_i : '0;
        rail_f_o = start ? rail_f_i : '0;
    end

endmodule

// File: rtl/dr_bit_resolve.sv
module dr_bit_resolve
    import dr_detect_pkg::*;
#(
    parameter int N = 8
) (
    input  logic [N-1:0] rail_t,
    input  logic [N-1:0] rail_f,
    output logic [N-1:0] complete,
    output logic [N-1:0] value,
    output logic [N-1:0] illegal
);

    for (genvar i = 0; i < N; i++) begin : g_bit
        pair_code_t code;
        assign code = pair_code_t'({rail_t[i], rail_f[i]});

        always_comb begin
            complete[i] = 1'b0;
            value[i]    = 1'b0;
            illegal[i]  = 1'b0;
            unique case (code)
                PAIR_SPACER: ;
                PAIR_ZERO:   complete[i] = 1'b1;
                PAIR_ONE: begin
                    complete[i] = 1'b1;
                    value[i]    = 1'b1;
                end
                PAIR_FAULT: begin
                    complete[i] = 1'b1;
                    value[i]    = 1'b1;
                    illegal[i]  = 1'b1;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/dr_word_reduce.sv
module dr_word_reduce #(
    parameter int N = 8
) (
    input  logic [N-1:0] complete,
    input  logic [N-1:0] illegal,
    output logic         all_complete,
    output logic         any_illegal
);

    always_comb begin
        all_complete = &complete;
        any_illegal  = |illegal;
    end

endmodule

// File: rtl/dr_done_detect.sv
module dr_done_detect
    import dr_detect_pkg::*;
#(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [N-1:0] rail_t,
    input  logic [N-1:0] rail_f,
    output logic         done,
    output logic         err,
    output logic [N-1:0] word
);

    localparam int W = N;

    typedef struct packed {
        logic         done;
        logic         err;
        logic [W-1:0] word;
    } det_state_t;

    logic [W-1:0] gated_t, gated_f;
    logic [W-1:0] bit_complete, bit_value, bit_illegal;
    logic         all_complete, any_illegal;

    det_state_t state_d, state_q;

    dr_rail_gate #(.N(W)) u_gate (
        .start    (start),
        .rail_t_i (rail_t),
        .rail_f_i (rail_f),
        .rail_t_o (gated_t),
        .rail_f_o (gated_f)
    );

    dr_bit_resolve #(.N(W)) u_resolve (
        .rail_t   (gated_t),
        .rail_f   (gated_f),
        .complete (bit_complete),
        .value    (bit_value),
        .illegal  (bit_illegal)
    );

    dr_word_reduce #(.N(W)) u_reduce (
        .complete     (bit_complete),
        .illegal      (bit_illegal),
        .all_complete (all_complete),
        .any_illegal  (any_illegal)
    );

    always_comb begin
        state_d      = state_q;
        state_d.done = all_complete;
        state_d.err  = any_illegal;
        state_d.word = all_complete ? bit_value : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign done = state_q.done;
    assign err  = state_q.err;
    assign word = state_q.word;

endmodule

// File: rtl/dr_done_detect_chk.sv
module dr_done_detect_chk #(
    parameter int N = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic [N-1:0] rail_t,
    input logic [N-1:0] rail_f,
    input logic         done,
    input logic         err,
    input logic [N-1:0] word
);

    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (!done && !err && word == '0));

    assert_spacer_phase_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> !done);

    assert_word_complete_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (start && (&(rail_t | rail_f))) |=> done);

    assert_pending_bit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !(&(rail_t | rail_f))) |=> !done);

    assert_decode_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (start && (&(rail_t | rail_f))) |=> (word == $past(rail_t)));

    assert_word_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> (word == '0));

    assert_fault_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (start && (|(rail_t & rail_f))) |=> err);

    assert_fault_masked_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> !err);

endmodule

bind dr_done_detect dr_done_detect_chk #(.N(N)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .rail_t (rail_t),
    .rail_f (rail_f),
    .done   (done),
    .err    (err),
    .word   (word)
);

// File: tb/dr_done_detect_test.sv
module dr_done_detect_test;

    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [N-1:0] rail_t = '0;
    logic [N-1:0] rail_f = '0;
    logic         done;
    logic         err;
    logic [N-1:0] word;

    int n_checks = 0;
    int n_fails  = 0;

    always #4 clk = ~clk;

    dr_done_detect #(.N(N)) uut (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .rail_t (rail_t),
        .rail_f (rail_f),
        .done   (done),
        .err    (err),
        .word   (word)
    );

    task automatic check(input string tag, input string what,
                         input logic [N-1:0] act, input logic [N-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // Drive at a falling edge, let one rising edge pass, check at the next falling edge
    task automatic step(input logic s, input logic [N-1:0] t,
                        input logic [N-1:0] f, input string tag);
        logic          e_done;
        logic          e_err;
        logic [N-1:0]  e_word;
        start  = s;
        rail_t = t;
        rail_f = f;
        e_done = s && ((t | f) == {N{1'b1}});
        e_err  = s && ((t & f) != '0);
        e_word = e_done ? t : '0;
        @(negedge clk);
        check(tag, "done", N'(done), N'(e_done));
        check(tag, "err",  N'(err),  N'(e_err));
        check(tag, "word", word, e_word);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        // R1: outputs clear during reset, rails driven as if complete
        start  = 1'b1;
        rail_t = 8'hA5;
        rail_f = 8'h5A;
        repeat (2) @(negedge clk);
        check("R1", "done", N'(done), '0);
        check("R1", "err",  N'(err),  '0);
        check("R1", "word", word, '0);
        start = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "word", word, '0);

        // R3, R5: every word value with all bits resolved
        for (int v = 0; v < (1 << N); v++) begin
            step(1'b1, N'(v), ~N'(v), "R3_R5");
        end

        // R2, R6, R8: start low, rails complete or faulty
        for (int v = 0; v < (1 << N); v += 7) begin
            step(1'b0, N'(v), ~N'(v), "R2_R6");
            step(1'b0, N'(v), N'(v) | 8'h01, "R8");
        end

        // R4, R6: each bit left in spacer in turn
        for (int i = 0; i < N; i++) begin
            logic [N-1:0] t;
            logic [N-1:0] f;
            t = N'($urandom);
            f = ~t;
            t[i] = 1'b0;
            f[i] = 1'b0;
            step(1'b1, t, f, "R4_R6");
        end

        // R7, R9: each bit driven to fault code in turn
        for (int i = 0; i < N; i++) begin
            logic [N-1:0] t;
            logic [N-1:0] f;
            t = N'($urandom);
            f = ~t;
            t[i] = 1'b1;
            f[i] = 1'b1;
            step(1'b1, t, f, "R7_R9");
        end

        // R2, R3, R4, R5: tokens resolving bit by bit after random delays
        for (int k = 0; k < 60; k++) begin
            int           delay [N];
            int           last;
            logic [N-1:0] val;
            logic [N-1:0] t;
            logic [N-1:0] f;
            val  = N'($urandom);
            last = 0;
            for (int i = 0; i < N; i++) begin
                delay[i] = int'($urandom % 6);
                if (delay[i] > last) last = delay[i];
            end
            step(1'b0, '0, '0, "R2");
            for (int c = 0; c <= last + 1; c++) begin
                t = '0;
                f = '0;
                for (int i = 0; i < N; i++) begin
                    if (c >= delay[i]) begin
                        t[i] = val[i];
                        f[i] = ~val[i];
                    end
                end
                step(1'b1, t, f, "R3_R4_R5");
            end
            step(1'b0, val, ~val, "R2");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule